// File: doc/BRIEF.md
# SIMT Branch Divergence Mask Unit

This block keeps the execution mask and the current program counter of one 32-lane warp while that warp runs through conditional branches. All lanes share one instruction stream. When a branch splits the lanes, the warp is not broken apart. Instead, the unit disables the lanes that are not on the current path and runs the two sides of the branch one after the other. It runs the taken side first and the not-taken side second. When both sides have finished, it brings back the mask that was active before the branch.

The sequencer receives a branch event with a per-lane condition vector and three program counters: the taken target, the fall-through target and the reconvergence point. It also receives an else event, which marks the end of the taken side, and a reconverge event, which marks arrival at the join point. The unit answers with the program counter and the 32-bit mask to use from the next cycle on. Nested divergence is held on a reconvergence stack of `DEPTH` entries. Each entry holds the mask to restore, the join PC, the mask of the not-taken side still to run and that side's PC.

Controller states:
- IDLE: no divergence is open.
- FIRST: the taken side of the innermost split is running, and the not-taken side is still pending.
- SECOND: the not-taken side of the innermost split is running.

Transitions:
- IDLE→FIRST or FIRST→FIRST or SECOND→FIRST: a divergent branch, which pushes an entry.
- FIRST→SECOND: a reconverge or else event, which switches to the pending side.
- SECOND→IDLE, SECOND→FIRST or SECOND→SECOND: a reconverge event, which pops an entry. The next state follows the phase of the entry underneath.

Top module: `simt_div_unit`

## Requirements
- R1: Reset state. After reset, `exec_mask` is 32'hFFFF_FFFF, `cur_pc` equals `RESET_PC` (default 0), `nest_ovf` is 0 and no divergence is open.
- R2: Uniform taken branch. If every active lane has its condition bit set, a branch sets `cur_pc` to `br_taken_pc` on the next cycle. The mask is unchanged and nothing is pushed, so a later reconverge event is ignored. Bit i of `br_cond` and of `exec_mask` both belong to lane i.
- R3: Uniform not-taken branch. If no active lane has its condition bit set, the empty taken side is skipped without an execution pass. `cur_pc` becomes `br_fall_pc`, the mask is unchanged and nothing is pushed.
- R4: Divergent branch. If some active lanes have the condition bit set and some do not, then on the next cycle `exec_mask` equals the old mask AND `br_cond`, and `cur_pc` equals `br_taken_pc`.
- R5: Switch to the pending side. While the taken side runs (FIRST), a reconverge or else event makes `exec_mask` equal to the mask before the branch AND NOT `br_cond`, and sets `cur_pc` to that branch's `br_fall_pc`.
- R6: Restore at the join point. While the not-taken side runs (SECOND), a reconverge event restores the mask from before the branch and sets `cur_pc` to that branch's `br_join_pc`. The enclosing split then resumes in its own phase.
- R7: Ignored events. An else event in SECOND or IDLE has no effect. A reconverge event in IDLE has no effect.
- R8: Nesting limit. Up to `DEPTH` (default 8) divergent branches can nest. A divergent branch with the stack full changes neither the mask nor the PC. It sets `nest_ovf`, which stays set until reset.
- R9: Single-lane paths. A path with exactly one active lane (for example `br_cond` = 32'h8000_0000 under the full mask) runs with that single bit set in `exec_mask`.
- R10: Event priority. If several events are asserted in the same cycle, branch wins over reconverge, and reconverge wins over else.
- R11: Non-empty mask. `exec_mask` is never all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| br_evt | input | 1 | A branch is evaluated this cycle |
| else_evt | input | 1 | The taken side has reached its end |
| recon_evt | input | 1 | The current path has reached the join point |
| br_cond | input | 32 | Per-lane branch condition, bit i belongs to lane i |
| br_taken_pc | input | 32 | Target PC of the taken side |
| br_fall_pc | input | 32 | PC of the not-taken side |
| br_join_pc | input | 32 | PC where both sides meet again |
| cur_pc | output | 32 | PC the warp executes |
| exec_mask | output | 32 | Active-lane mask |
| nest_ovf | output | 1 | Sticky nesting overflow flag |

## Verification
Four kinds of condition vector are used:
- All-set and all-clear vectors show that a uniform branch only redirects the PC.
- Checkerboard and half-split vectors show that a real split is detected and that the two masks are complementary.
- Single-bit vectors and vectors that peel off the lowest lane reach one-lane paths and fill the stack to its limit, where the overflow flag and the frozen mask are observed.

Sequences of nested splits show whether the enclosing split resumes in the right phase. Events raised in the same cycle test the priority order. A long random stream of events, compared with a per-lane reference model, finds mismatches in the order of the masks that directed cases do not reach.

// File: rtl/simt_pkg.sv
`timescale 1ns/1ps
package simt_pkg;
    localparam int SIMT_LANES = 32;
    localparam int SIMT_PCW   = 32;

    typedef logic [SIMT_LANES-1:0] lane_mask_t;
    typedef logic [SIMT_PCW-1:0]   pc_t;

    typedef enum logic [1:0] {
        S_IDLE   = 2'd0,
        S_FIRST  = 2'd1,
        S_SECOND = 2'd2
    } div_state_e;

    typedef struct packed {
        pc_t        join_pc;
        lane_mask_t saved_mask;
        lane_mask_t pend_mask;
        pc_t        pend_pc;
    } recon_ent_t;
endpackage

// File: rtl/simt_lane_split.sv
`timescale 1ns/1ps
module simt_lane_split
    import simt_pkg::*;
(
    input  lane_mask_t cur_mask,
    input  lane_mask_t cond,
    output lane_mask_t tk_mask,
    output lane_mask_t nt_mask,
    output logic       tk_any,
    output logic       nt_any
);
    genvar g;
    generate
        for (g = 0; g < SIMT_LANES; g++) begin : g_lane
            assign tk_mask[g] = cur_mask[g] &  cond[g];
            assign nt_mask[g] = cur_mask[g] & ~cond[g];
        end
    endgenerate

    assign tk_any = |tk_mask;
    assign nt_any = |nt_mask;
endmodule

// File: rtl/simt_recon_stack.sv
`timescale 1ns/1ps
module simt_recon_stack
    import simt_pkg::*;
#(
    parameter int DEPTH = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       push,
    input  recon_ent_t push_ent,
    input  logic       pop,
    input  logic       clr_pend,
    output recon_ent_t top_ent,
    output logic       below_pend_any,
    output logic       empty,
    output logic       full,
    output logic       last
);
    localparam int CW = $clog2(DEPTH + 1);
    localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    recon_ent_t       mem [DEPTH];
    logic [CW-1:0]    cnt;
    logic [IW-1:0]    top_idx;
    logic [IW-1:0]    below_idx;

    assign top_idx   = IW'(cnt - CW'(1));
    assign below_idx = IW'(cnt - CW'(2));
    assign empty     = (cnt == '0);
    assign full      = (cnt == CW'(DEPTH));
    assign last      = (cnt == CW'(1));
    assign top_ent   = empty ? '0 : mem[top_idx];
    assign below_pend_any = (cnt >= CW'(2)) && (|mem[below_idx].pend_mask);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (push) begin
            mem[IW'(cnt)] <= push_ent;
            cnt           <= cnt + CW'(1);
        end else if (pop) begin
            cnt <= cnt - CW'(1);
        end else if (clr_pend) begin
            mem[top_idx].pend_mask <= '0;
        end
    end

    // R8: the controller never pushes onto a full stack
    a_r8_no_push_full: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> !full);
    // R7: the controller never pops an empty stack
    a_r7_no_pop_empty: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> !empty);
    // R5: a pending side is only cleared when one exists
    a_r5_clr_nonempty: assert property (@(posedge clk) disable iff (!rst_n)
        clr_pend |-> !empty && (top_ent.pend_mask != '0));
endmodule

// File: rtl/simt_div_ctrl.sv
`timescale 1ns/1ps
module simt_div_ctrl
    import simt_pkg::*;
#(
    parameter pc_t RESET_PC = '0
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       br_evt,
    input  logic       else_evt,
    input  logic       recon_evt,
    input  pc_t        br_taken_pc,
    input  pc_t        br_fall_pc,
    input  pc_t        br_join_pc,
    input  lane_mask_t tk_mask,
    input  lane_mask_t nt_mask,
    input  logic       tk_any,
    input  logic       nt_any,
    input  recon_ent_t top_ent,
    input  logic       below_pend_any,
    input  logic       empty,
    input  logic       full,
    input  logic       last,
    output lane_mask_t exec_mask,
    output pc_t        cur_pc,
    output logic       nest_ovf,
    output logic       push,
    output recon_ent_t push_ent,
    output logic       pop,
    output logic       clr_pend
);
    div_state_e st, st_n;
    lane_mask_t mask_n;
    pc_t        pc_n;
    logic       ovf_n;

    always_comb begin
        st_n     = st;
        mask_n   = exec_mask;
        pc_n     = cur_pc;
        ovf_n    = nest_ovf;
        push     = 1'b0;
        pop      = 1'b0;
        clr_pend = 1'b0;
        push_ent = '{join_pc: br_join_pc, saved_mask: exec_mask,
                     pend_mask: nt_mask, pend_pc: br_fall_pc};
        if (br_evt) begin
            if (!tk_any) begin
                pc_n = br_fall_pc;
            end else if (!nt_any) begin
                pc_n = br_taken_pc;
            end else if (full) begin
                ovf_n = 1'b1;
            end else begin
                push   = 1'b1;
                mask_n = tk_mask;
                pc_n   = br_taken_pc;
                st_n   = S_FIRST;
            end
        end else if (recon_evt || else_evt) begin
            unique case (st)
                S_IDLE: begin
                end
                S_FIRST: begin
                    mask_n   = top_ent.pend_mask;
                    pc_n     = top_ent.pend_pc;
                    clr_pend = 1'b1;
                    st_n     = S_SECOND;
                end
                S_SECOND: begin
                    if (recon_evt) begin
                        pop    = 1'b1;
                        mask_n = top_ent.saved_mask;
                        pc_n   = top_ent.join_pc;
                        if (last)
                            st_n = S_IDLE;
                        else if (below_pend_any)
                            st_n = S_FIRST;
                        else
                            st_n = S_SECOND;
                    end
                end
                default: begin
                end
            endcase
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) st <= S_IDLE;
        else        st <= st_n;
    end

    // output registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            exec_mask <= '1;
            cur_pc    <= RESET_PC;
            nest_ovf  <= 1'b0;
        end else begin
            exec_mask <= mask_n;
            cur_pc    <= pc_n;
            nest_ovf  <= ovf_n;
        end
    end

    // R11: some lane is always active
    a_r11_mask_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
        exec_mask != '0);
    // R8: overflow flag is sticky
    a_r8_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        nest_ovf |=> nest_ovf);
    // R2: a uniform branch leaves the mask and the state alone
    a_r2_uniform_hold: assert property (@(posedge clk) disable iff (!rst_n)
        br_evt && !(tk_any && nt_any) |=> $stable(exec_mask) && $stable(st));
    // R4: inside a split the mask is a subset of the mask to restore
    a_r4_mask_subset: assert property (@(posedge clk) disable iff (!rst_n)
        (st != S_IDLE) |-> ((exec_mask & ~top_ent.saved_mask) == '0));
    // R6: controller state agrees with stack occupancy
    a_r6_idle_empty: assert property (@(posedge clk) disable iff (!rst_n)
        (st == S_IDLE) |-> empty);
    a_r6_busy_nonempty: assert property (@(posedge clk) disable iff (!rst_n)
        (st != S_IDLE) |-> !empty);
    // R5: in the first phase a pending side always exists
    a_r5_first_pending: assert property (@(posedge clk) disable iff (!rst_n)
        (st == S_FIRST) |-> (top_ent.pend_mask != '0));
endmodule

// File: rtl/simt_div_unit.sv
`timescale 1ns/1ps
module simt_div_unit
    import simt_pkg::*;
#(
    parameter int  DEPTH    = 8,
    parameter pc_t RESET_PC = '0
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        br_evt,
    input  logic        else_evt,
    input  logic        recon_evt,
    input  logic [31:0] br_cond,
    input  logic [31:0] br_taken_pc,
    input  logic [31:0] br_fall_pc,
    input  logic [31:0] br_join_pc,
    output logic [31:0] cur_pc,
    output logic [31:0] exec_mask,
    output logic        nest_ovf
);
    lane_mask_t tk_mask, nt_mask;
    logic       tk_any, nt_any;
    recon_ent_t top_ent, push_ent;
    logic       below_pend_any, empty, full, last;
    logic       push, pop, clr_pend;

    simt_lane_split u_split (
        .cur_mask (exec_mask),
        .cond     (br_cond),
        .tk_mask  (tk_mask),
        .nt_mask  (nt_mask),
        .tk_any   (tk_any),
        .nt_any   (nt_any)
    );

    simt_recon_stack #(.DEPTH(DEPTH)) u_stack (
        .clk            (clk),
        .rst_n          (rst_n),
        .push           (push),
        .push_ent       (push_ent),
        .pop            (pop),
        .clr_pend       (clr_pend),
        .top_ent        (top_ent),
        .below_pend_any (below_pend_any),
        .empty          (empty),
        .full           (full),
        .last           (last)
    );

    simt_div_ctrl #(.RESET_PC(RESET_PC)) u_ctrl (
        .clk            (clk),
        .rst_n          (rst_n),
        .br_evt         (br_evt),
        .else_evt       (else_evt),
        .recon_evt      (recon_evt),
        .br_taken_pc    (br_taken_pc),
        .br_fall_pc     (br_fall_pc),
        .br_join_pc     (br_join_pc),
        .tk_mask        (tk_mask),
        .nt_mask        (nt_mask),
        .tk_any         (tk_any),
        .nt_any         (nt_any),
        .top_ent        (top_ent),
        .below_pend_any (below_pend_any),
        .empty          (empty),
        .full           (full),
        .last           (last),
        .exec_mask      (exec_mask),
        .cur_pc         (cur_pc),
        .nest_ovf       (nest_ovf),
        .push           (push),
        .push_ent       (push_ent),
        .pop            (pop),
        .clr_pend       (clr_pend)
    );
endmodule

// File: tb/sim_simt_div_unit.sv
`timescale 1ns/1ps
module sim_simt_div_unit;
    localparam int DEPTH = 8;
    localparam int MAXD  = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        br_evt = 1'b0, else_evt = 1'b0, recon_evt = 1'b0;
    logic [31:0] br_cond = '0, br_taken_pc = '0, br_fall_pc = '0, br_join_pc = '0;
    logic [31:0] cur_pc, exec_mask;
    logic        nest_ovf;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    // reference model state
    logic [31:0] m_mask, m_pc;
    bit          m_ovf;
    int          m_cnt;
    logic [31:0] m_saved [MAXD];
    logic [31:0] m_pend  [MAXD];
    logic [31:0] m_ppc   [MAXD];
    logic [31:0] m_jpc   [MAXD];

    always #4 clk = ~clk;

    simt_div_unit #(.DEPTH(DEPTH), .RESET_PC(32'h0)) u0 (
        .clk(clk), .rst_n(rst_n), .br_evt(br_evt), .else_evt(else_evt),
        .recon_evt(recon_evt), .br_cond(br_cond), .br_taken_pc(br_taken_pc),
        .br_fall_pc(br_fall_pc), .br_join_pc(br_join_pc), .cur_pc(cur_pc),
        .exec_mask(exec_mask), .nest_ovf(nest_ovf)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic chk_all(input string tag);
        chk({tag, " mask"}, exec_mask, m_mask);
        chk({tag, " pc"}, cur_pc, m_pc);
        chk({tag, " ovf"}, {31'b0, nest_ovf}, {31'b0, m_ovf});
        chk("R11 mask nonzero", {31'b0, exec_mask != 0}, 32'd1);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        m_mask = '1; m_pc = '0; m_ovf = 1'b0; m_cnt = 0;
    endtask

    task automatic model(input bit br, input bit el, input bit rc, input logic [31:0] cond,
                         input logic [31:0] tpc, input logic [31:0] fpc, input logic [31:0] jpc);
        logic [31:0] tk, nt;
        tk = m_mask & cond;
        nt = m_mask & ~cond;
        if (br) begin
            if (tk == 0) m_pc = fpc;
            else if (nt == 0) m_pc = tpc;
            else if (m_cnt == DEPTH) m_ovf = 1'b1;
            else begin
                m_saved[m_cnt] = m_mask; m_pend[m_cnt] = nt;
                m_ppc[m_cnt] = fpc; m_jpc[m_cnt] = jpc;
                m_cnt++;
                m_mask = tk; m_pc = tpc;
            end
        end else if ((rc || el) && m_cnt > 0) begin
            if (m_pend[m_cnt-1] != 0) begin
                m_mask = m_pend[m_cnt-1]; m_pc = m_ppc[m_cnt-1];
                m_pend[m_cnt-1] = 0;
            end else if (rc) begin
                m_mask = m_saved[m_cnt-1]; m_pc = m_jpc[m_cnt-1];
                m_cnt--;
            end
        end
    endtask

    task automatic ev(input bit br, input bit el, input bit rc, input logic [31:0] cond,
                      input logic [31:0] tpc, input logic [31:0] fpc, input logic [31:0] jpc,
                      input string tag);
        @(negedge clk);
        br_evt = br; else_evt = el; recon_evt = rc;
        br_cond = cond; br_taken_pc = tpc; br_fall_pc = fpc; br_join_pc = jpc;
        @(posedge clk);
        #1;
        br_evt = 1'b0; else_evt = 1'b0; recon_evt = 1'b0;
        model(br, el, rc, cond, tpc, fpc, jpc);
        @(negedge clk);
        chk_all(tag);
    endtask

    task automatic branch(input logic [31:0] cond, input logic [31:0] tpc,
                          input logic [31:0] fpc, input logic [31:0] jpc, input string tag);
        ev(1'b1, 1'b0, 1'b0, cond, tpc, fpc, jpc, tag);
    endtask

    task automatic recon(input string tag);
        ev(1'b0, 1'b0, 1'b1, 32'h0, 32'h0, 32'h0, 32'h0, tag);
    endtask

    task automatic els(input string tag);
        ev(1'b0, 1'b1, 1'b0, 32'h0, 32'h0, 32'h0, 32'h0, tag);
    endtask

    task automatic t_reset();
        do_reset();
        @(negedge clk);
        chk("R1 reset mask", exec_mask, 32'hFFFF_FFFF);
        chk("R1 reset pc", cur_pc, 32'h0);
        chk("R1 reset ovf", {31'b0, nest_ovf}, 32'h0);
        recon("R1 nothing open");
    endtask

    task automatic t_uniform();
        do_reset();
        branch(32'hFFFF_FFFF, 32'h40, 32'h44, 32'h80, "R2 uniform taken");
        chk("R2 mask kept", exec_mask, 32'hFFFF_FFFF);
        recon("R7 recon ignored when idle");
        chk("R7 pc kept", cur_pc, 32'h40);
        branch(32'h0, 32'h50, 32'h54, 32'h90, "R3 uniform not-taken");
        chk("R3 pc fall", cur_pc, 32'h54);
        branch(32'h0000_FFFF, 32'h60, 32'h64, 32'hA0, "R4 split");
        branch(32'hFFFF_0000, 32'h70, 32'h74, 32'hB0, "R3 empty taken side skipped");
        chk("R3 mask after skip", exec_mask, 32'h0000_FFFF);
        recon("R5 go to other side");
        recon("R6 restore");
        chk("R6 full mask", exec_mask, 32'hFFFF_FFFF);
    endtask

    task automatic t_diverge();
        do_reset();
        branch(32'h0F0F_0F0F, 32'h100, 32'h200, 32'h300, "R4 checker split");
        chk("R4 taken mask", exec_mask, 32'h0F0F_0F0F);
        recon("R5 not-taken side");
        chk("R5 nt mask", exec_mask, 32'hF0F0_F0F0);
        chk("R5 nt pc", cur_pc, 32'h200);
        recon("R6 join");
        chk("R6 join pc", cur_pc, 32'h300);
    endtask

    task automatic t_else();
        do_reset();
        branch(32'hAAAA_5555, 32'h10, 32'h20, 32'h30, "R4 split");
        els("R5 else switch");
        chk("R5 else mask", exec_mask, 32'h5555_AAAA);
        els("R7 else ignored in second phase");
        chk("R7 mask kept", exec_mask, 32'h5555_AAAA);
        recon("R6 restore after else");
        els("R7 else ignored when idle");
    endtask

    task automatic t_nested();
        do_reset();
        branch(32'h0000_FFFF, 32'h100, 32'h180, 32'h1F0, "R4 outer");
        branch(32'h0000_00FF, 32'h110, 32'h120, 32'h130, "R4 inner");
        chk("R4 inner mask", exec_mask, 32'h0000_00FF);
        recon("R5 inner nt");
        chk("R5 inner nt mask", exec_mask, 32'h0000_FF00);
        recon("R6 inner join");
        chk("R6 inner restore", exec_mask, 32'h0000_FFFF);
        chk("R6 inner join pc", cur_pc, 32'h130);
        recon("R6 outer resumes first phase");
        chk("R6 outer nt mask", exec_mask, 32'hFFFF_0000);
        branch(32'h00FF_0000, 32'h140, 32'h150, 32'h160, "R4 nested in second");
        recon("R5 nested nt");
        recon("R6 nested join");
        chk("R6 back in outer second", exec_mask, 32'hFFFF_0000);
        recon("R6 outer join");
        chk("R6 outer join pc", cur_pc, 32'h1F0);
        chk("R6 outer mask", exec_mask, 32'hFFFF_FFFF);
    endtask

    task automatic t_single();
        do_reset();
        branch(32'h8000_0000, 32'h8, 32'hC, 32'h10, "R9 one lane");
        chk("R9 single bit", exec_mask, 32'h8000_0000);
        chk("R9 count one", $countones(exec_mask), 32'd1);
        recon("R9 complement");
        chk("R9 complement mask", exec_mask, 32'h7FFF_FFFF);
        recon("R9 join");
    endtask

    task automatic t_priority();
        do_reset();
        branch(32'h0000_0F0F, 32'h10, 32'h20, 32'h30, "R4 split");
        ev(1'b1, 1'b1, 1'b1, 32'h0000_000F, 32'h40, 32'h50, 32'h60, "R10 branch wins");
        chk("R10 branch mask", exec_mask, 32'h0000_000F);
        recon("R5 inner nt");
        ev(1'b0, 1'b1, 1'b1, 32'h0, 32'h0, 32'h0, 32'h0, "R10 recon over else");
        chk("R10 popped", cur_pc, 32'h60);
        recon("R5 outer nt");
        recon("R6 outer join");
    endtask

    task automatic t_overflow();
        do_reset();
        for (int i = 0; i < DEPTH; i++) begin
            branch(m_mask & (m_mask - 32'd1), 32'h1000 + i, 32'h2000 + i, 32'h3000 + i,
                   "R8 fill");
        end
        branch(m_mask & (m_mask - 32'd1), 32'h4000, 32'h5000, 32'h6000, "R8 overflow");
        chk("R8 ovf set", {31'b0, nest_ovf}, 32'd1);
        chk("R8 mask frozen", exec_mask, 32'hFFFF_FF00);
        recon("R9 peeled lane");
        chk("R9 single lane", $countones(exec_mask), 32'd1);
        for (int i = 0; i < 2 * DEPTH - 1; i++) recon("R8 unwind");
        chk("R8 full restore", exec_mask, 32'hFFFF_FFFF);
        chk("R8 still set", {31'b0, nest_ovf}, 32'd1);
        do_reset();
        @(negedge clk);
        chk("R1 reset clears ovf", {31'b0, nest_ovf}, 32'd0);
    endtask

    task automatic t_random();
        do_reset();
        for (int i = 0; i < 400; i++) begin
            int unsigned k;
            logic [31:0] c;
            k = $urandom_range(0, 99);
            c = $urandom;
            if ($urandom_range(0, 9) == 0) c = m_mask;
            if (k < 45) branch(c, $urandom, $urandom, $urandom, "R4 random branch");
            else if (k < 80) recon("R6 random recon");
            else els("R5 random else");
        end
    endtask

    task automatic finish_up();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        #(8 * 150000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired");
        finish_up();
    end

    initial begin
        t_reset();
        t_uniform();
        t_diverge();
        t_else();
        t_nested();
        t_single();
        t_priority();
        t_random();
        t_overflow();
        finish_up();
    end
endmodule